// File: doc/BRIEF.md
# DMA Global Control and Interrupt Unit

This unit is the shared register block that sits beside up to 32 DMA channel engines. It holds the controller-wide enable, turns software doorbell writes into one-cycle descriptor-fetch start pulses for individual channels, and collects channel events into pending registers. Each channel signals a finished descriptor chain, a finished descriptor, a halt and an address error. These pulses set bits that software reads and later clears.

Chain-completion events and per-descriptor events are kept in two separate pending registers. Each has its own clear method. The chain register is cleared by writing back a keep-mask, and the descriptor register is cleared through a dedicated write-one-to-clear address. Halt and address-error pulses from any channel set two sticky summary bits in the control word. Software can set aside one channel for an interrupt controller: its chain event then drives a private interrupt output and is removed from the combined line. Software can also mark channels as programmed by another agent, and doorbells for those channels are dropped.

Top module: `dma_glbctl`

## Requirements
- R1: After reset every register reads 0, and fetch_go, dma_irq, desc_irq and ictl_irq are 0.
- R2: The control word at byte offset 0x1000 stores a global enable in bit 0, a special-channel enable in bit 1, a routing enable in bit 16 and a routed channel number in bits [21:17]. All of these read back as written.
- R3: Control bit 2 (address-error summary) and bit 3 (halt summary) are set in the cycle after any ch_addr_err or ch_halt pulse. A control write with the bit at 0 clears it. A write with the bit at 1 leaves it unchanged, so software can never set it.
- R4: Chain pending at 0x1004 has one bit per channel and is set by ch_done. A write to 0x1004 keeps the bits written as 1 and clears the bits written as 0.
- R5: Descriptor pending at 0x1010 is set by ch_desc_done, and writes to 0x1010 are ignored. Writing 1 to a bit at 0x1014 clears that pending bit. 0x1014 reads 0.
- R6: When an event sets a pending or summary bit in the same cycle that software clears it, the bit ends up set.
- R7: A write to the doorbell at 0x100C raises fetch_go for exactly one cycle, in the cycle after the write, on the written 1 bits. The doorbell reads 0.
- R8: The programmed-channel mask at 0x101C is read/write. Doorbell bits for channels set in the mask are dropped, and all doorbells are dropped while the global enable is 0.
- R9: dma_irq is the OR of all chain pending bits except the routed channel. ictl_irq is the routed channel's chain pending bit, and it is used only while the routing enable is 1.
- R10: desc_irq is the OR of all descriptor pending bits.
- R11: Reads of any other offset return 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 13 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| ch_done | input | 32 | Per-channel chain-finished pulses |
| ch_desc_done | input | 32 | Per-channel descriptor-finished pulses |
| ch_halt | input | 32 | Per-channel halt pulses |
| ch_addr_err | input | 32 | Per-channel address-error pulses |
| fetch_go | output | 32 | Per-channel descriptor-fetch start pulses |
| dma_irq | output | 1 | Combined chain interrupt |
| desc_irq | output | 1 | Combined descriptor interrupt |
| ictl_irq | output | 1 | Interrupt of the routed channel |

## Verification
The hardest case to reach is an event pulse that lands in the same cycle as the software write meant to clear the same bit. This case matters for the chain keep-mask, the descriptor clear register and the halt summary alike. Random traffic rarely lines these up, so directed steps drive the register write and the channel pulse together in one bus cycle on a bit that is already pending. A reference model then compares every output on every clock. That comparison also covers the long random run, which moves the routed channel while chain events keep arriving.

// File: rtl/dmagc_pkg.sv
package dmagc_pkg;
  localparam int unsigned OFS_CTRL  = 32'h1000;
  localparam int unsigned OFS_CHAIN = 32'h1004;
  localparam int unsigned OFS_BELL  = 32'h100C;
  localparam int unsigned OFS_DPEND = 32'h1010;
  localparam int unsigned OFS_DCLR  = 32'h1014;
  localparam int unsigned OFS_PMASK = 32'h101C;

  localparam int CB_EN     = 0;
  localparam int CB_SPC    = 1;
  localparam int CB_AERR   = 2;
  localparam int CB_HALT   = 3;
  localparam int CB_RTE    = 16;
  localparam int CB_RCH_LO = 17;
  localparam int RCH_W     = 5;

  typedef enum logic {CLR_KEEP_MASK, CLR_WRITE_ONES} clr_mode_e;

  typedef struct packed {
    logic [RCH_W-1:0] rch;
    logic             rte;
    logic             halt;
    logic             aerr;
    logic             spc;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/dmagc_pend_bank.sv
module dmagc_pend_bank
  import dmagc_pkg::*;
#(
  parameter int        N    = 32,
  parameter clr_mode_e MODE = CLR_KEEP_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_nxt, kept;

  if (MODE == CLR_KEEP_MASK) begin : g_keep
    assign kept = clr_stb ? (pend_q & clr_data) : pend_q;
  end else begin : g_w1c
    assign kept = clr_stb ? (pend_q & ~clr_data) : pend_q;
  end

  always_comb begin
    pend_nxt = kept | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assign pend_o = pend_q;

  // R6: an event is never lost to a same-cycle clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R4: a clear alone never raises a bit
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/dmagc_ctrl.sv
module dmagc_ctrl
  import dmagc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  ctrl_t        wfield,
  input  logic [N-1:0] halt_in,
  input  logic [N-1:0] aerr_in,
  output ctrl_t        ctrl_o
);
  ctrl_t c_q, c_nxt;

  always_comb begin
    c_nxt = c_q;
    if (wr_stb) begin
      c_nxt.en   = wfield.en;
      c_nxt.spc  = wfield.spc;
      c_nxt.rte  = wfield.rte;
      c_nxt.rch  = wfield.rch;
      c_nxt.aerr = c_q.aerr & wfield.aerr;
      c_nxt.halt = c_q.halt & wfield.halt;
    end
    c_nxt.aerr = c_nxt.aerr | (|aerr_in);
    c_nxt.halt = c_nxt.halt | (|halt_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= '0;
    else        c_q <= c_nxt;
  end

  assign ctrl_o = c_q;

  // R3: any halt pulse leaves the summary set
  a_r3_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|halt_in) |=> c_q.halt);

  // R3: software alone cannot raise the halt summary
  a_r3_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_q.halt && !(|halt_in)) |=> !c_q.halt);

  // R3: address-error summary follows any error pulse
  a_r3_aerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|aerr_in) |=> c_q.aerr);
endmodule

// File: rtl/dmagc_bell.sv
module dmagc_bell #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [N-1:0] wdata,
  input  logic         glb_en,
  input  logic [N-1:0] pmask,
  output logic [N-1:0] fetch_go
);
  logic [N-1:0] go_q, go_nxt;

  always_comb begin
    go_nxt = '0;
    if (wr_stb && glb_en) go_nxt = wdata & ~pmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= '0;
    else        go_q <= go_nxt;
  end

  assign fetch_go = go_q;

  // R8: masked channels stay quiet
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((go_q & $past(pmask)) == '0));

  // R8: no pulse while globally disabled
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (go_q == '0));

  // R7: a pulse only follows a doorbell write
  a_r7_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q != '0) |-> $past(wr_stb));
endmodule

// File: rtl/dma_glbctl.sv
module dma_glbctl
  import dmagc_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic [NUM_CH-1:0] ch_desc_done,
  input  logic [NUM_CH-1:0] ch_halt,
  input  logic [NUM_CH-1:0] ch_addr_err,
  output logic [NUM_CH-1:0] fetch_go,
  output logic              dma_irq,
  output logic              desc_irq,
  output logic              ictl_irq
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic wr, rd;
  logic hit_ctrl, hit_chain, hit_bell, hit_dpend, hit_dclr, hit_pmask;

  assign wr        = reg_en & reg_we;
  assign rd        = reg_en & ~reg_we;
  assign hit_ctrl  = (reg_addr == ADDR_W'(OFS_CTRL));
  assign hit_chain = (reg_addr == ADDR_W'(OFS_CHAIN));
  assign hit_bell  = (reg_addr == ADDR_W'(OFS_BELL));
  assign hit_dpend = (reg_addr == ADDR_W'(OFS_DPEND));
  assign hit_dclr  = (reg_addr == ADDR_W'(OFS_DCLR));
  assign hit_pmask = (reg_addr == ADDR_W'(OFS_PMASK));

  ctrl_t ctrl, wfield;
  always_comb begin
    wfield      = '0;
    wfield.en   = reg_wdata[CB_EN];
    wfield.spc  = reg_wdata[CB_SPC];
    wfield.aerr = reg_wdata[CB_AERR];
    wfield.halt = reg_wdata[CB_HALT];
    wfield.rte  = reg_wdata[CB_RTE];
    wfield.rch  = reg_wdata[CB_RCH_LO +: RCH_W];
  end

  dmagc_ctrl #(.N(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .wr_stb(wr & hit_ctrl), .wfield(wfield),
    .halt_in(ch_halt), .aerr_in(ch_addr_err), .ctrl_o(ctrl)
  );

  logic [NUM_CH-1:0] chain_pend, desc_pend;

  dmagc_pend_bank #(.N(NUM_CH), .MODE(CLR_KEEP_MASK)) u_chain (
    .clk(clk), .rst_n(rst_sn), .set_i(ch_done), .clr_stb(wr & hit_chain),
    .clr_data(reg_wdata[NUM_CH-1:0]), .pend_o(chain_pend)
  );

  dmagc_pend_bank #(.N(NUM_CH), .MODE(CLR_WRITE_ONES)) u_desc (
    .clk(clk), .rst_n(rst_sn), .set_i(ch_desc_done), .clr_stb(wr & hit_dclr),
    .clr_data(reg_wdata[NUM_CH-1:0]), .pend_o(desc_pend)
  );

  logic [NUM_CH-1:0] pmask_q, pmask_nxt;
  always_comb begin
    pmask_nxt = pmask_q;
    if (wr && hit_pmask) pmask_nxt = reg_wdata[NUM_CH-1:0];
  end
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pmask_q <= '0;
    else         pmask_q <= pmask_nxt;
  end

  dmagc_bell #(.N(NUM_CH)) u_bell (
    .clk(clk), .rst_n(rst_sn), .wr_stb(wr & hit_bell),
    .wdata(reg_wdata[NUM_CH-1:0]), .glb_en(ctrl.en), .pmask(pmask_q),
    .fetch_go(fetch_go)
  );

  logic [NUM_CH-1:0] route_oh;
  assign route_oh = ctrl.rte ? (NUM_CH'(1) << ctrl.rch) : '0;
  assign dma_irq  = |(chain_pend & ~route_oh);
  assign ictl_irq = |(chain_pend & route_oh);
  assign desc_irq = |desc_pend;

  logic [DATA_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[CB_EN]               = ctrl.en;
    ctrl_word[CB_SPC]              = ctrl.spc;
    ctrl_word[CB_AERR]             = ctrl.aerr;
    ctrl_word[CB_HALT]             = ctrl.halt;
    ctrl_word[CB_RTE]              = ctrl.rte;
    ctrl_word[CB_RCH_LO +: RCH_W]  = ctrl.rch;
  end

  always_comb begin
    reg_rdata = '0;
    if (rd) begin
      if (hit_ctrl)       reg_rdata = ctrl_word;
      else if (hit_chain) reg_rdata = DATA_W'(chain_pend);
      else if (hit_dpend) reg_rdata = DATA_W'(desc_pend);
      else if (hit_pmask) reg_rdata = DATA_W'(pmask_q);
    end
  end

  // R9: a routed event never reaches the private line without routing
  a_r9_route_needs_enable: assert property (@(posedge clk) disable iff (!rst_sn)
    ictl_irq |-> ctrl.rte);

  // R9: an unrouted chain event raises the combined line
  a_r9_chain_raises: assert property (@(posedge clk) disable iff (!rst_sn)
    (((ch_done & ~route_oh) != '0) && !(wr && hit_ctrl)) |=> dma_irq);

  // R10: a descriptor event raises the descriptor line
  a_r10_desc_raises: assert property (@(posedge clk) disable iff (!rst_sn)
    (ch_desc_done != '0) |=> desc_irq);
endmodule

// File: tb/dma_glbctl_test.sv
module dma_glbctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_en, reg_we;
  logic [12:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [31:0] ch_done, ch_desc_done, ch_halt, ch_addr_err, fetch_go;
  logic        dma_irq, desc_irq, ictl_irq;

  always #5 clk = ~clk;

  dma_glbctl uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_done(ch_done), .ch_desc_done(ch_desc_done), .ch_halt(ch_halt),
    .ch_addr_err(ch_addr_err), .fetch_go(fetch_go), .dma_irq(dma_irq),
    .desc_irq(desc_irq), .ictl_irq(ictl_irq)
  );

  localparam logic [12:0] A_CTRL = 13'h1000, A_CHAIN = 13'h1004, A_BELL = 13'h100C,
                          A_DPEND = 13'h1010, A_DCLR = 13'h1014, A_PMASK = 13'h101C;

  int total = 0, bad = 0;
  bit finished = 0, run_cmp = 0;

  // reference model state
  bit        m_en, m_spc, m_rte, m_aerr, m_halt;
  bit [4:0]  m_rch;
  bit [31:0] m_chain, m_desc, m_mask, m_go;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] m_ctrl_word();
    bit [31:0] v = '0;
    v[0] = m_en; v[1] = m_spc; v[2] = m_aerr; v[3] = m_halt;
    v[16] = m_rte; v[21:17] = m_rch;
    return v;
  endfunction

  function automatic bit [31:0] m_route();
    return m_rte ? (32'h1 << m_rch) : 32'h0;
  endfunction

  always @(posedge clk) begin
    bit wr;
    bit [31:0] w;
    if (!rst_n) begin
      m_en = 0; m_spc = 0; m_rte = 0; m_aerr = 0; m_halt = 0; m_rch = 0;
      m_chain = 0; m_desc = 0; m_mask = 0; m_go = 0;
    end else begin
      wr = reg_en && reg_we;
      w  = reg_wdata;
      m_go = (wr && reg_addr == A_BELL && m_en) ? (w & ~m_mask) : 32'h0;
      if (wr && reg_addr == A_CTRL) begin
        m_en = w[0]; m_spc = w[1]; m_rte = w[16]; m_rch = w[21:17];
        m_aerr = m_aerr & w[2]; m_halt = m_halt & w[3];
      end
      m_aerr = m_aerr | (|ch_addr_err);
      m_halt = m_halt | (|ch_halt);
      if (wr && reg_addr == A_CHAIN) m_chain = m_chain & w;
      m_chain = m_chain | ch_done;
      if (wr && reg_addr == A_DCLR) m_desc = m_desc & ~w;
      m_desc = m_desc | ch_desc_done;
      if (wr && reg_addr == A_PMASK) m_mask = w;
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && run_cmp) begin
      chk("R7", fetch_go, m_go);
      chk("R9", {31'b0, dma_irq},  {31'b0, |(m_chain & ~m_route())});
      chk("R9", {31'b0, ictl_irq}, {31'b0, |(m_chain & m_route())});
      chk("R10", {31'b0, desc_irq}, {31'b0, |m_desc});
      if (reg_en && !reg_we) begin
        case (reg_addr)
          A_CTRL: begin
            chk("R2", reg_rdata & ~32'hC, m_ctrl_word() & ~32'hC);
            chk("R3", reg_rdata & 32'hC, m_ctrl_word() & 32'hC);
          end
          A_CHAIN: chk("R4", reg_rdata, m_chain);
          A_DPEND: chk("R5", reg_rdata, m_desc);
          A_DCLR:  chk("R5", reg_rdata, 32'h0);
          A_BELL:  chk("R7", reg_rdata, 32'h0);
          A_PMASK: chk("R8", reg_rdata, m_mask);
          default: chk("R11", reg_rdata, 32'h0);
        endcase
      end
    end
  end

  task automatic op(bit en, bit we, logic [12:0] a, logic [31:0] d,
                    logic [31:0] dn, logic [31:0] dd, logic [31:0] h, logic [31:0] ae);
    @(negedge clk);
    reg_en = en; reg_we = we; reg_addr = a; reg_wdata = d;
    ch_done = dn; ch_desc_done = dd; ch_halt = h; ch_addr_err = ae;
    @(posedge clk);
    #3;
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    op(1, 1, a, d, 0, 0, 0, 0);
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    op(1, 0, a, 0, 0, 0, 0, 0);
    d = reg_rdata;
  endtask

  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [12:0] addrs [8];
    addrs = '{A_CTRL, A_CHAIN, A_BELL, A_DPEND, A_DCLR, A_PMASK, 13'h1008, 13'h0000};
    rst_n = 0; reg_en = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    ch_done = 0; ch_desc_done = 0; ch_halt = 0; ch_addr_err = 0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1", fetch_go, 0);
    chk("R1", {29'b0, dma_irq, desc_irq, ictl_irq}, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) idle();
    run_cmp = 1;

    // R1: register reset values
    rd(A_CTRL, v);  chk("R1", v, 0);
    rd(A_CHAIN, v); chk("R1", v, 0);
    rd(A_DPEND, v); chk("R1", v, 0);
    rd(A_PMASK, v); chk("R1", v, 0);

    // R2: control fields; enable, special, route to channel 5
    wr(A_CTRL, 32'h000B0003);
    rd(A_CTRL, v); chk("R2", v, 32'h000B0003);

    // R3: summaries set by pulses, cleared by 0, untouched by 1
    op(0, 0, 0, 0, 0, 0, 32'h80, 32'h4);
    rd(A_CTRL, v); chk("R3", v, 32'h000B000F);
    wr(A_CTRL, 32'h000B000F);
    rd(A_CTRL, v); chk("R3", v, 32'h000B000F);
    wr(A_CTRL, 32'h000B0007);
    rd(A_CTRL, v); chk("R3", v, 32'h000B0007);
    wr(A_CTRL, 32'h000B0003);
    wr(A_CTRL, 32'h000B000F);
    rd(A_CTRL, v); chk("R3", v, 32'h000B0003);

    // R4 / R9: chain pending with channel 5 routed
    op(0, 0, 0, 0, 32'h222, 0, 0, 0);
    chk("R9", {30'b0, dma_irq, ictl_irq}, 32'h3);
    rd(A_CHAIN, v); chk("R4", v, 32'h222);
    wr(A_CHAIN, 32'hFFFFFFFD);
    rd(A_CHAIN, v); chk("R4", v, 32'h220);
    wr(A_CHAIN, 32'hFFFFFDFF);
    chk("R9", {30'b0, dma_irq, ictl_irq}, 32'h1);
    wr(A_CHAIN, 32'h0);
    chk("R9", {30'b0, dma_irq, ictl_irq}, 32'h0);

    // R5 / R10: descriptor pending and its clear register
    op(0, 0, 0, 0, 0, 32'h8001, 0, 0);
    chk("R10", {31'b0, desc_irq}, 1);
    wr(A_DPEND, 32'h0);
    rd(A_DPEND, v); chk("R5", v, 32'h8001);
    wr(A_DCLR, 32'h1);
    rd(A_DPEND, v); chk("R5", v, 32'h8000);
    wr(A_DCLR, 32'h8000);
    chk("R10", {31'b0, desc_irq}, 0);

    // R6: set and clear of the same bit in one cycle
    op(0, 0, 0, 0, 32'h40, 32'h4, 0, 0);
    op(1, 1, A_CHAIN, 32'h0, 32'h40, 0, 0, 0);
    rd(A_CHAIN, v); chk("R6", v, 32'h40);
    op(1, 1, A_DCLR, 32'h4, 0, 32'h4, 0, 0);
    rd(A_DPEND, v); chk("R6", v, 32'h4);
    op(1, 1, A_CTRL, 32'h000B0003, 0, 0, 32'h1, 0);
    rd(A_CTRL, v); chk("R6", v, 32'h000B000B);
    wr(A_CTRL, 32'h000B0003);
    wr(A_CHAIN, 32'h0);
    wr(A_DCLR, 32'hFFFFFFFF);

    // R7: doorbell pulse timing
    wr(A_BELL, 32'h11);
    chk("R7", fetch_go, 32'h11);
    idle();
    chk("R7", fetch_go, 32'h0);
    rd(A_BELL, v); chk("R7", v, 0);

    // R8: mask and global enable gate the doorbell
    wr(A_PMASK, 32'h10);
    rd(A_PMASK, v); chk("R8", v, 32'h10);
    wr(A_BELL, 32'h11);
    chk("R8", fetch_go, 32'h01);
    wr(A_CTRL, 32'h000B0002);
    wr(A_BELL, 32'hFF);
    chk("R8", fetch_go, 32'h0);
    wr(A_CTRL, 32'h000B0003);
    wr(A_PMASK, 32'h0);

    // R11: unmapped offsets
    wr(13'h1008, 32'hFFFFFFFF);
    rd(13'h1008, v); chk("R11", v, 0);
    rd(13'h1018, v); chk("R11", v, 0);
    rd(A_CTRL, v);   chk("R11", v, 32'h000B0003);

    // mixed random traffic, compared every clock
    for (int i = 0; i < 3000; i++) begin
      op($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
         addrs[$urandom_range(0, 7)], $urandom(),
         $urandom() & $urandom() & $urandom(),
         $urandom() & $urandom() & $urandom(),
         ($urandom_range(0, 15) == 0) ? ($urandom() & $urandom()) : 32'h0,
         ($urandom_range(0, 15) == 0) ? ($urandom() & $urandom()) : 32'h0);
    end
    idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule